// File: doc/BRIEF.md
# Edge-Select GPIO Port with Interrupt

This block is a general-purpose I/O port, 16 pins wide by default, controlled through a simple register port with an address and a data word. Software sets each pin as an input or an output. It loads an output value, and for every input it picks which edge counts as an event: rising or falling. Output pins drive their stored value onto the pads. Input pins have their transitions compared against the previous input sample.

An event on an input pin that is not masked sets a sticky status bit. A single interrupt line stays high while any status bit is set. Software clears status bits by writing ones to them. The input-data register returns the sampled pin levels gated by a pin-control register. Accesses that are not full-word are rejected.

Top module: `egpio_port`

## Requirements
- R1: After reset, status reads 0, `irq` is 0, and `pin_out` is 0. Reset values: direction 0xFFFF (all inputs), output 0x0000, edge-select 0x0000, mask 0xFFFF, pin-control 0xFFFF.
- R2: `pin_out[i]` equals the stored output bit where direction bit i is 0, and is 0 where direction bit i is 1 (input).
- R3: For an input pin with edge-select bit 1, a 0-to-1 change on `pin_in` is an event. With edge-select bit 0, a 1-to-0 change is an event. The status bit is visible two rising clock edges after the pin changes: one sampling stage, then the status register.
- R4: An edge is recorded only when the pin's direction bit is 1 and its mask bit is 0. A masked pin or an output pin never sets status.
- R5: `irq` is 1 exactly while at least one status bit is set.
- R6: A full-word write to status offset 0x14 clears the bits written as 1 and leaves the bits written as 0 untouched. If an event arrives on a bit in the same cycle as its clear, the bit stays set.
- R7: A read of offset 0x00 returns the sampled pins ANDed with the pin-control register at 0x18. Writes to 0x00 change nothing.
- R8: A write to direction offset 0x08 updates `pin_out` on the next cycle: pins that become outputs drive their stored output bit.
- R9: Accesses with `bus_wide` = 0 are rejected: writes change no register, and reads return 0.
- R10: Offsets 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 read back the output, direction, edge-select, mask, status and pin-control registers. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = full-word access; 0 is rejected |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, combinational while selected |
| pin_in | input | N | Pad input levels |
| pin_out | output | N | Pad output levels (0 on input pins) |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest situation to reach from the ports is an event and a clear of the same status bit landing on one clock edge, because the event is hidden behind the sampling register. The bench changes the pin at a falling clock edge. After the next rising edge has captured the new sample, it issues the write-to-clear, so both act on the following edge. The bench then reads status to confirm the event survived, and a second clear removes it.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
    // Register byte offsets; software depends on these
    localparam int OFF_DIN  = 'h00;
    localparam int OFF_DOUT = 'h04;
    localparam int OFF_DIR  = 'h08;
    localparam int OFF_EDGE = 'h0C;
    localparam int OFF_MASK = 'h10;
    localparam int OFF_STAT = 'h14;
    localparam int OFF_PCTL = 'h18;
endpackage

// File: rtl/egpio_edge_cell.sv
module egpio_edge_cell (
    input  logic cur_i,
    input  logic prev_i,
    input  logic rise_sel_i,
    input  logic is_input_i,
    input  logic masked_i,
    output logic hit_o
);
    logic rose, fell, match;
    always_comb begin
        rose  = cur_i & ~prev_i;
        fell  = ~cur_i & prev_i;
        match = rise_sel_i ? rose : fell;
        hit_o = match & is_input_i & ~masked_i;
    end
endmodule

// File: rtl/egpio_rdmux.sv
module egpio_rdmux #(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      smp_i,
    input  logic [N-1:0]      dout_i,
    input  logic [N-1:0]      dir_i,
    input  logic [N-1:0]      edge_i,
    input  logic [N-1:0]      mask_i,
    input  logic [N-1:0]      stat_i,
    input  logic [N-1:0]      pctl_i,
    output logic [N-1:0]      rdata_o
);
    import egpio_pkg::*;
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if      (addr_i == ADDR_W'(OFF_DIN))  rdata_o = smp_i & pctl_i;
            else if (addr_i == ADDR_W'(OFF_DOUT)) rdata_o = dout_i;
            else if (addr_i == ADDR_W'(OFF_DIR))  rdata_o = dir_i;
            else if (addr_i == ADDR_W'(OFF_EDGE)) rdata_o = edge_i;
            else if (addr_i == ADDR_W'(OFF_MASK)) rdata_o = mask_i;
            else if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = stat_i;
            else if (addr_i == ADDR_W'(OFF_PCTL)) rdata_o = pctl_i;
        end
    end
endmodule

// File: rtl/egpio_port.sv
module egpio_port #(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic              irq
);
    import egpio_pkg::*;

    localparam logic [N-1:0] ALL1 = {N{1'b1}};

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] dir;
        logic [N-1:0] edge_sel;
        logic [N-1:0] mask;
        logic [N-1:0] pctl;
        logic [N-1:0] stat;
        logic [N-1:0] smp;
        logic [N-1:0] prev;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] hit;
    logic         wr_ok, rd_ok;

    // per-pin edge qualifiers
    for (genvar i = 0; i < N; i++) begin : g_pin
        egpio_edge_cell u_cell (
            .cur_i     (st_q.smp[i]),
            .prev_i    (st_q.prev[i]),
            .rise_sel_i(st_q.edge_sel[i]),
            .is_input_i(st_q.dir[i]),
            .masked_i  (st_q.mask[i]),
            .hit_o     (hit[i])
        );
    end

    always_comb begin
        wr_ok = bus_sel & bus_we & bus_wide;
        rd_ok = bus_sel & ~bus_we & bus_wide;
        st_d      = st_q;
        st_d.smp  = pin_in;
        st_d.prev = st_q.smp;
        if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFF_DOUT)) st_d.dout     = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_DIR))  st_d.dir      = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_EDGE)) st_d.edge_sel = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_MASK)) st_d.mask     = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_PCTL)) st_d.pctl     = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_STAT)) st_d.stat     = st_q.stat & ~bus_wdata;
        end
        // a fresh event outranks a clear of the same bit
        st_d.stat = st_d.stat | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dout     <= '0;
            st_q.dir      <= ALL1;
            st_q.edge_sel <= '0;
            st_q.mask     <= ALL1;
            st_q.pctl     <= ALL1;
            st_q.stat     <= '0;
            st_q.smp      <= '0;
            st_q.prev     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    egpio_rdmux #(.N(N), .ADDR_W(ADDR_W)) u_rd (
        .rd_en_i(rd_ok),
        .addr_i (bus_addr),
        .smp_i  (st_q.smp),
        .dout_i (st_q.dout),
        .dir_i  (st_q.dir),
        .edge_i (st_q.edge_sel),
        .mask_i (st_q.mask),
        .stat_i (st_q.stat),
        .pctl_i (st_q.pctl),
        .rdata_o(bus_rdata)
    );

    assign pin_out = st_q.dout & ~st_q.dir;
    assign irq     = |st_q.stat;

    // plain views for the bound checker
    logic [N-1:0] dir_view, dout_view, hit_view;
    assign dir_view  = st_q.dir;
    assign dout_view = st_q.dout;
    assign hit_view  = hit;
endmodule

// File: rtl/egpio_port_chk.sv
module egpio_port_chk #(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      pin_out,
    input logic              irq,
    input logic [N-1:0]      dir_view,
    input logic [N-1:0]      dout_view,
    input logic [N-1:0]      hit_view
);
    import egpio_pkg::*;

    logic stat_wr;
    assign stat_wr = bus_sel && bus_we && bus_wide && bus_addr == ADDR_W'(OFF_STAT);

    a_r3_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_view != '0) |=> irq);

    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_wr) |=> irq);

    a_r6_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata == {N{1'b1}} && hit_view == '0) |=> !irq);

    a_r8_dir_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_wide && bus_addr == ADDR_W'(OFF_DIR))
        |=> pin_out == (dout_view & ~$past(bus_wdata)));

    a_r9_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_wide) |=> ($stable(dir_view) && $stable(dout_view)));

    a_r9_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !bus_wide) |-> bus_rdata == '0);

    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr > ADDR_W'(OFF_PCTL)) |-> bus_rdata == '0);
endmodule

bind egpio_port egpio_port_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq),
    .dir_view(dir_view), .dout_view(dout_view), .hit_view(hit_view)
);

// File: tb/sim_egpio_port.sv
module sim_egpio_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_we = 0, bus_wide = 1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;   // 250 MHz

    egpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic wide = 1);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wide = 1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic wide = 1);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_wide = wide;
        #1 d = bus_rdata;
        bus_sel = 0; bus_wide = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd(8'h14, rv); check("R1 status", rv, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
        check("R1 pin_out", pin_out, 16'h0000);
        rd(8'h08, rv); check("R1 dir", rv, 16'hFFFF);
        rd(8'h10, rv); check("R1 mask", rv, 16'hFFFF);
        rd(8'h18, rv); check("R1 pinctl", rv, 16'hFFFF);
        rd(8'h0C, rv); check("R1 edge", rv, 16'h0000);
    endtask

    task automatic t_pad();
        wr(8'h04, 16'h3C5A);
        wr(8'h08, 16'h00FF);
        idle(1);
        check("R2 pad split", pin_out, 16'h3C00);
        rd(8'h04, rv); check("R10 dout readback", rv, 16'h3C5A);
    endtask

    task automatic t_dirchange();
        wr(8'h08, 16'h0F0F);
        check("R8 pad after dir write", pin_out, 16'h3050);
        wr(8'h08, 16'hFFFF);
        check("R8 all inputs", pin_out, 16'h0000);
    endtask

    task automatic t_rise();
        wr(8'h0C, 16'h0001);
        wr(8'h10, 16'hFFFC);
        @(negedge clk); pin_in[0] = 1;
        @(negedge clk);
        check("R3 not yet after one edge", {15'b0, irq}, 16'h0000);
        @(negedge clk);
        check("R3 rise irq", {15'b0, irq}, 16'h0001);
        rd(8'h14, rv); check("R3 rise status", rv, 16'h0001);
        @(negedge clk); pin_in[0] = 0;   // falling on rising-select: no event
        idle(3);
        wr(8'h14, 16'h0001);
        rd(8'h14, rv); check("R6 cleared", rv, 16'h0000);
        check("R5 irq low", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_fall();
        @(negedge clk); pin_in[1] = 1;
        idle(3);
        rd(8'h14, rv); check("R3 rise ignored on fall-select", rv, 16'h0000);
        @(negedge clk); pin_in[1] = 0;
        idle(3);
        rd(8'h14, rv); check("R3 fall status", rv, 16'h0002);
        wr(8'h14, 16'h0001);
        rd(8'h14, rv); check("R6 zero bit untouched", rv, 16'h0002);
        check("R5 irq held", {15'b0, irq}, 16'h0001);
        wr(8'h14, 16'h0002);
        check("R5 irq drops", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_qualify();
        // bit2 masked (falling select), bit0 made an output
        wr(8'h08, 16'hFFFE);
        @(negedge clk); pin_in[2] = 1; pin_in[0] = 1;
        idle(3);
        @(negedge clk); pin_in[2] = 0; pin_in[0] = 0;
        idle(3);
        rd(8'h14, rv); check("R4 masked or output no status", rv, 16'h0000);
        check("R4 irq low", {15'b0, irq}, 16'h0000);
        wr(8'h08, 16'hFFFF);
    endtask

    task automatic t_race();
        @(negedge clk); pin_in[0] = 1;
        @(negedge clk);   // sample taken; event pending
        bus_sel = 1; bus_we = 1; bus_addr = 8'h14; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        rd(8'h14, rv); check("R6 event beats clear", rv, 16'h0001);
        wr(8'h14, 16'h0001);
        rd(8'h14, rv); check("R6 later clear", rv, 16'h0000);
        wr(8'h10, 16'hFFFF);
        @(negedge clk); pin_in[0] = 0;
        idle(3);
    endtask

    task automatic t_inread();
        @(negedge clk); pin_in = 16'hA5A5;
        idle(2);
        wr(8'h18, 16'hFF00);
        rd(8'h00, rv); check("R7 gated input", rv, 16'hA500);
        wr(8'h00, 16'h1234);
        rd(8'h00, rv); check("R7 write ignored", rv, 16'hA500);
        rd(8'h18, rv); check("R10 pinctl readback", rv, 16'hFF00);
        wr(8'h18, 16'hFFFF);
        @(negedge clk); pin_in = 16'h0000;
        idle(3);
    endtask

    task automatic t_badwidth();
        wr(8'h04, 16'hFFFF, 1'b0);
        rd(8'h04, rv); check("R9 narrow write ignored", rv, 16'h3C5A);
        rd(8'h04, rv, 1'b0); check("R9 narrow read zero", rv, 16'h0000);
    endtask

    task automatic t_unmapped();
        rd(8'h1C, rv); check("R10 unmapped 0x1C", rv, 16'h0000);
        rd(8'h06, rv); check("R10 unaligned 0x06", rv, 16'h0000);
        rd(8'h10, rv); check("R10 mask readback", rv, 16'hFFFF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        t_reset();
        t_pad();
        t_dirchange();
        t_rise();
        t_fall();
        t_qualify();
        wr(8'h0C, 16'h0001);
        wr(8'h10, 16'hFFFE);
        t_race();
        t_inread();
        t_badwidth();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule